// File: doc/BRIEF.md
# Lockout Chip Hello Reader

This block performs the opening exchange with a cartridge security chip: it clocks four bits out of the chip over a two-wire link and reports the 4-bit greeting value the chip returns. The block drives the clock line. It samples the data line, which is pulled up, at fixed points in each bit period. All timing is counted in pulses of a one-microsecond tick input. The system clock can therefore run at any rate. Only the tick input has to be accurate.

A host pulses `start_i`. The block then runs four bit periods. Each bit period has three parts: the clock is low for a setup wait, then the data line is sampled, then the clock stays low for a hold wait, then the clock goes high for a gap wait. After the fourth bit the block stores the assembled value, maps it to a region code, and raises `done_o` for one cycle. The stored results stay on the outputs until the next read completes.

The controller has five states.
- `ST_IDLE`: clock high, waiting for a start.
- `ST_LOW_SETUP`: clock low, counting the setup time.
- `ST_LOW_HOLD`: clock low, counting the hold time.
- `ST_HIGH_GAP`: clock high, counting the gap time.
- `ST_REPORT`: the one-cycle completion state.

The transitions are:
- start: `ST_IDLE` to `ST_LOW_SETUP`.
- sample: `ST_LOW_SETUP` to `ST_LOW_HOLD`, on setup expiry.
- release: `ST_LOW_HOLD` to `ST_HIGH_GAP`, on hold expiry.
- next-bit: `ST_HIGH_GAP` to `ST_LOW_SETUP`, on gap expiry with bits still missing.
- finish: `ST_HIGH_GAP` to `ST_REPORT`, on gap expiry with all bits taken.
- return: `ST_REPORT` to `ST_IDLE`.

Top module: `lockout_hello_reader`

## Requirements
- R1: After reset, `dclk_o` is 1, `done_o` is 0, `nibble_o` is 0 and `region_o` is 0xFF.
- R2: A `start_i` pulse seen in idle drives `dclk_o` low in the next cycle. Each read produces exactly four low pulses on `dclk_o`.
- R3: Within a bit, `dio_i` is sampled on the clock edge that carries the 10th `us_tick_i` pulse counted after `dclk_o` went low. A sampled level of 1 gives bit value 1 and a level of 0 gives bit value 0.
- R4: `dclk_o` stays low for 26 counted ticks in each bit period: 10 ticks before the sample and 16 after it. It then returns high.
- R5: After each rise of `dclk_o`, 20 ticks are counted before the next bit starts. This includes the last bit, where the 20 ticks come before `done_o`.
- R6: The first sampled bit lands in `nibble_o[3]` and the last one in `nibble_o[0]`.
- R7: `region_o` is 0x00 for nibble 0x5, 0x01 for nibble 0x1, and 0xFF for every other nibble.
- R8: `done_o` is high for exactly one cycle per read, with `dclk_o` high. `nibble_o` and `region_o` take their new values in that same cycle and do not change in any other cycle.
- R9: A `start_i` pulse in any state other than idle, including the completion cycle, is ignored. It does not affect timing, results or the clock line.
- R10: A tick in the same cycle as the accepted start pulse is not counted toward the setup time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick_i | input | 1 | One-cycle pulse per elapsed microsecond |
| start_i | input | 1 | Begin a read (accepted only in idle) |
| dio_i | input | 1 | Data line from the security chip (pulled up) |
| dclk_o | output | 1 | Clock line to the security chip, idles high |
| done_o | output | 1 | One-cycle completion pulse |
| nibble_o | output | 4 | Assembled greeting value, first bit in MSB |
| region_o | output | 8 | Decoded region: 0x00, 0x01 or 0xFF |

## Verification
Two pairs of events can fall in the same cycle. First, a start pulse can coincide with a tick. The bench waits for a cycle in which the tick is high and asserts start in that cycle. The read only passes if the design still counts a full 26 ticks of low clock, which shows the coincident tick was discarded. Second, a start pulse can coincide with the completion pulse. The bench asserts start exactly in the cycle where `done_o` is high. It then checks that no further clock-low phase begins and that the results are unchanged. Every nibble value is swept at two tick rates, and a stray start is also injected in the middle of the second bit.

// File: rtl/lhr_pkg.sv
package lhr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW_SETUP,
        ST_LOW_HOLD,
        ST_HIGH_GAP,
        ST_REPORT
    } lhr_state_t;

    localparam int          REGION_W       = 8;
    localparam logic [7:0]  REGION_PAL     = 8'h00;
    localparam logic [7:0]  REGION_NTSC    = 8'h01;
    localparam logic [7:0]  REGION_INVALID = 8'hFF;

endpackage

// File: rtl/lhr_us_timer.sv
module lhr_us_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    assign last_tick = (cnt_q == (target_i - 1'b1));
    assign expire_o  = run_i && tick_i && last_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the count never passes the wait length of the current phase
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < target_i));

    // R10: a cleared timer starts the next phase from zero
    a_r10_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/lhr_bit_shifter.sv
module lhr_bit_shifter #(
    parameter int NUM_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                shift_i,
    input  logic                bit_i,
    output logic [NUM_BITS-1:0] word_o,
    output logic                full_o
);

    localparam int TAKEN_W = $clog2(NUM_BITS + 1);

    logic [NUM_BITS-1:0] word_q;
    logic [TAKEN_W-1:0]  taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            taken_q <= '0;
        end else if (clr_i) begin
            word_q  <= '0;
            taken_q <= '0;
        end else if (shift_i) begin
            word_q  <= {word_q[NUM_BITS-2:0], bit_i};
            taken_q <= taken_q + 1'b1;
        end
    end

    assign word_o = word_q;
    assign full_o = (taken_q == TAKEN_W'(NUM_BITS));

    // R6: never more bits taken than the word holds
    a_r6_taken_bound: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> (taken_q < TAKEN_W'(NUM_BITS)));

endmodule

// File: rtl/lhr_region_map.sv
module lhr_region_map
    import lhr_pkg::*;
#(
    parameter int                NUM_BITS     = 4,
    parameter logic [NUM_BITS-1:0] PAL_PATTERN  = 4'h5,
    parameter logic [NUM_BITS-1:0] NTSC_PATTERN = 4'h1
) (
    input  logic [NUM_BITS-1:0] word_i,
    output logic [REGION_W-1:0] region_o
);

    always_comb begin
        if (word_i == PAL_PATTERN) begin
            region_o = REGION_PAL;
        end else if (word_i == NTSC_PATTERN) begin
            region_o = REGION_NTSC;
        end else begin
            region_o = REGION_INVALID;
        end
    end

endmodule

// File: rtl/lockout_hello_reader.sv
module lockout_hello_reader
    import lhr_pkg::*;
#(
    parameter int NUM_BITS = 4,
    parameter int SETUP_US = 10,
    parameter int HOLD_US  = 16,
    parameter int GAP_US   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                us_tick_i,
    input  logic                start_i,
    input  logic                dio_i,
    output logic                dclk_o,
    output logic                done_o,
    output logic [NUM_BITS-1:0] nibble_o,
    output logic [REGION_W-1:0] region_o
);

    localparam int MAX_US = (SETUP_US > HOLD_US) ?
                            ((SETUP_US > GAP_US) ? SETUP_US : GAP_US) :
                            ((HOLD_US  > GAP_US) ? HOLD_US  : GAP_US);
    localparam int CNT_W  = $clog2(MAX_US + 1);

    lhr_state_t state_q, state_d;

    logic                tmr_clr;
    logic                tmr_run;
    logic                tmr_expire;
    logic [CNT_W-1:0]    tmr_target;
    logic                sh_clr;
    logic                sh_take;
    logic                sh_full;
    logic [NUM_BITS-1:0] sh_word;
    logic [REGION_W-1:0] mapped;
    logic                result_load;
    logic [NUM_BITS-1:0] nibble_q;
    logic [REGION_W-1:0] region_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state and control ----------------
    always_comb begin
        state_d     = state_q;
        sh_clr      = 1'b0;
        sh_take     = 1'b0;
        result_load = 1'b0;
        tmr_run     = 1'b0;
        tmr_target  = CNT_W'(SETUP_US);
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_LOW_SETUP;
                    sh_clr  = 1'b1;
                end
            end
            ST_LOW_SETUP: begin
                tmr_run    = 1'b1;
                tmr_target = CNT_W'(SETUP_US);
                if (tmr_expire) begin
                    sh_take = 1'b1;
                    state_d = ST_LOW_HOLD;
                end
            end
            ST_LOW_HOLD: begin
                tmr_run    = 1'b1;
                tmr_target = CNT_W'(HOLD_US);
                if (tmr_expire) begin
                    state_d = ST_HIGH_GAP;
                end
            end
            ST_HIGH_GAP: begin
                tmr_run    = 1'b1;
                tmr_target = CNT_W'(GAP_US);
                if (tmr_expire) begin
                    if (sh_full) begin
                        state_d     = ST_REPORT;
                        result_load = 1'b1;
                    end else begin
                        state_d = ST_LOW_SETUP;
                    end
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign tmr_clr = (state_q == ST_IDLE) || tmr_expire;

    // ---------------- outputs ----------------
    always_comb begin
        dclk_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:      dclk_o = 1'b1;
            ST_LOW_SETUP: dclk_o = 1'b0;
            ST_LOW_HOLD:  dclk_o = 1'b0;
            ST_HIGH_GAP:  dclk_o = 1'b1;
            ST_REPORT:    done_o = 1'b1;
            default:      dclk_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nibble_q <= '0;
            region_q <= REGION_INVALID;
        end else if (result_load) begin
            nibble_q <= sh_word;
            region_q <= mapped;
        end
    end

    assign nibble_o = nibble_q;
    assign region_o = region_q;

    // ---------------- sub-blocks ----------------
    lhr_us_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .run_i    (tmr_run),
        .tick_i   (us_tick_i),
        .target_i (tmr_target),
        .expire_o (tmr_expire)
    );

    lhr_bit_shifter #(.NUM_BITS(NUM_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sh_clr),
        .shift_i (sh_take),
        .bit_i   (dio_i),
        .word_o  (sh_word),
        .full_o  (sh_full)
    );

    lhr_region_map #(.NUM_BITS(NUM_BITS)) u_map (
        .word_i   (sh_word),
        .region_o (mapped)
    );

    // ---------------- assertions ----------------
    // R8: completion lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: clock line is high while reporting
    a_r8_done_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> dclk_o);

    // R8: results only move in the completion cycle
    a_r8_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(region_o));

    a_r8_nibble_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(nibble_o));

    // R7: reported region agrees with reported nibble
    a_r7_pal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && region_o == REGION_PAL) |-> (nibble_o == NUM_BITS'(5)));

    // R9: a start while reporting does not reopen a read
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> dclk_o);

    // R2: the clock line only goes low during a read
    a_r2_low_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !dclk_o |-> (state_q != ST_IDLE));

endmodule

// File: tb/lockout_hello_reader_tb.sv
`timescale 1ns/1ps
module lockout_hello_reader_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       start = 1'b0;
    logic       dio = 1'b1;
    logic       dclk;
    logic       done;
    logic [3:0] nibble;
    logic [7:0] region;

    int tests = 0;
    int fails = 0;
    int tick_count = 0;
    int tick_period = 3;
    int tick_phase = 0;

    always #2.5 clk = ~clk;

    lockout_hello_reader u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick_i (us_tick),
        .start_i   (start),
        .dio_i     (dio),
        .dclk_o    (dclk),
        .done_o    (done),
        .nibble_o  (nibble),
        .region_o  (region)
    );

    // microsecond tick source, changing 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            us_tick = (tick_phase == 0);
            tick_phase = (tick_phase + 1 >= tick_period) ? 0 : tick_phase + 1;
        end
    end

    always @(posedge clk) begin
        if (us_tick === 1'b1) tick_count <= tick_count + 1;
    end

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    function automatic int exp_region(input int v);
        if (v == 5) return 8'h00;
        if (v == 1) return 8'h01;
        return 8'hFF;
    endfunction

    task automatic run_read(input logic [3:0] val, input bit align);
        int t0;
        int t1;
        logic bitv;
        @(negedge clk);
        // R10: when align is set the start coincides with a tick
        if (align) begin
            while (us_tick !== 1'b1) @(negedge clk);
        end else begin
            while (us_tick !== 1'b0) @(negedge clk);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(dclk === 1'b0, "R2 clock low after start", int'(dclk), 0);
        t1 = tick_count;
        for (int b = 0; b < 4; b++) begin
            while (dclk !== 1'b0) @(negedge clk);
            t0 = tick_count;
            bitv = val[3-b];
            dio = ~bitv;
            if (b == 1) begin
                // R9: stray start in the middle of a read
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            while (tick_count < t0 + 5) @(negedge clk);
            dio = bitv;
            while (tick_count < t0 + 11) @(negedge clk);
            dio = ~bitv;
            while (dclk !== 1'b1) @(negedge clk);
            check(tick_count - t0 == 26, "R4 R10 low phase ticks", tick_count - t0, 26);
            t1 = tick_count;
            dio = 1'b1;
        end
        while (done !== 1'b1) begin
            @(negedge clk);
            if (dclk === 1'b0) begin
                check(1'b0, "R2 extra low pulse", 1, 0);
                while (dclk === 1'b0) @(negedge clk);
            end
        end
        check(tick_count - t1 == 20, "R5 final gap ticks", tick_count - t1, 20);
        check(nibble == val, "R3 R6 nibble", int'(nibble), int'(val));
        check(int'(region) == exp_region(int'(val)), "R7 region code", int'(region), exp_region(int'(val)));
        check(dclk === 1'b1, "R8 clock high at done", int'(dclk), 1);
        start = 1'b1;  // R9: start in the completion cycle
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b0, "R8 done single cycle", int'(done), 0);
        repeat (6) @(negedge clk);
        check(dclk === 1'b1 && nibble == val, "R9 start at done ignored",
              int'(dclk), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog expired actual=190000 expected=fewer cycles");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(dclk === 1'b1, "R1 reset clock", int'(dclk), 1);
        check(done === 1'b0, "R1 reset done", int'(done), 0);
        check(nibble === 4'h0, "R1 reset nibble", int'(nibble), 0);
        check(region === 8'hFF, "R1 reset region", int'(region), 255);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dclk === 1'b1 && done === 1'b0, "R1 idle after reset", int'(dclk), 1);
        for (int p = 0; p < 2; p++) begin
            tick_period = (p == 0) ? 3 : 5;
            for (int v = 0; v < 16; v++) begin
                run_read(v[3:0], v[0] ^ p[0]);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule